// File: doc/BRIEF.md
# SM3 Iterative Compression Core

This block computes the SM3 compression function for one 512-bit message block. It runs one round per clock over 64 rounds and works on a 256-bit chaining value. A start strobe loads the eight working words. The chaining value comes either from an input port or from the built-in SM3 initial value. The expanded message arrives as one pair per round: the word W_j and its companion W'_j, on a valid/ready interface. The round constant is made inside the core. The message expander is a separate block and feeds this interface.

When the last round is accepted, the core XORs the working words into the stored chaining value. It raises a one-cycle done pulse and holds the new chaining value on its output until the next start. To hash a longer message, feed that output back as the chaining input for the following block. Padding, length counting and byte ordering belong to the surrounding logic.

Top module: `sm3_cmp_core`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, w_ready_o and done_o are all low.
- R2: When start_i is high and the core is idle, the core loads the chaining value at the next clock edge and busy_o is high from the following cycle. The value loaded is the SM3 initial value 7380166F 4914B2B9 172442D7 DA8A0600 A96F30BC 163138AA E38DEE4D B0FB0E4E if use_iv_i=1, and cv_i otherwise. Bits [255:224] hold word A and bits [31:0] hold word H.
- R3: w_ready_o equals busy_o in every cycle. It is low while idle even when w_valid_i is high.
- R4: A round advances only on a clock edge where w_valid_i and w_ready_o are both high. A low w_valid_i stalls the round count and the working words. done_o rises in the cycle after the 64th accepted word pair.
- R5: Round j forms SS1, SS2, TT1 and TT2 from the working words, W_j, W'_j and the constant ROTL(T_j, j mod 32). T_j is 0x79CC4519 for j<16 and 0x7A879D8A otherwise. Rounds 0–15 use three-input XOR for both boolean functions. Later rounds use majority on A,B,C and choose on E,F,G. E receives P0(TT2), C receives ROTL(B,9) and G receives ROTL(F,19).
- R6: The result on cv_o is the final working words XORed bitwise with the chaining value that was loaded.
- R7: A start_i pulse while busy_o is high has no effect on the round count, the working words or the result.
- R8: done_o is high for exactly one cycle, and busy_o is low in that same cycle. cv_o then holds the result until the next start, whatever the word interface does.
- R9: A second block started with use_iv_i=0 and cv_i set to the previous cv_o continues the hash. The two-block digest matches the SM3 digest of the 64-byte message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a block (taken only while idle) |
| use_iv_i | input | 1 | Load the SM3 initial value instead of cv_i |
| cv_i | input | 256 | Chaining value input, A in the top word |
| w_valid_i | input | 1 | Word pair valid |
| w_i | input | 32 | Expanded message word W_j |
| wp_i | input | 32 | Companion word W'_j = W_j ^ W_j+4 |
| w_ready_o | output | 1 | Word pair accepted at the next edge when valid |
| busy_o | output | 1 | Compression in progress |
| done_o | output | 1 | One-cycle pulse when cv_o is updated |
| cv_o | output | 256 | Chaining value result, A in the top word |

## Verification
The bench builds the core with its default parameters: 64 rounds, of which the first 16 use the parity functions. With these values the results can be compared against published SM3 digests. One is the three-byte message "abc", which needs one block. The other is a 64-byte message, which needs a second padding block chained from the first. The same settings let a stalled feed and a start pulse in mid-block be checked against a cycle-by-cycle reference model. That model is written with word arrays and its own message expansion.

// File: rtl/sm3_cmp_pkg.sv
`timescale 1ns/1ps
package sm3_cmp_pkg;
    localparam int WORD_W = 32;
    localparam int NWORDS = 8;
    localparam int CV_W   = WORD_W * NWORDS;
    localparam int ROT_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    // Word A occupies the most significant position, H the least.
    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } wstate_t;

    localparam logic [CV_W-1:0] SM3_IV =
        256'h7380166f_4914b2b9_172442d7_da8a0600_a96f30bc_163138aa_e38dee4d_b0fb0e4e;

    localparam word_t T_EARLY = 32'h79cc4519;
    localparam word_t T_LATE  = 32'h7a879d8a;

    function automatic word_t rotl_k(input word_t x, input int k);
        return (x << k) | (x >> (WORD_W - k));
    endfunction

    function automatic word_t rotl_v(input word_t x, input logic [ROT_W-1:0] k);
        return (x << k) | (x >> (WORD_W - int'(k)));
    endfunction

    function automatic word_t perm0(input word_t x);
        return x ^ rotl_k(x, 9) ^ rotl_k(x, 17);
    endfunction
endpackage

// File: rtl/sm3_tconst.sv
`timescale 1ns/1ps
module sm3_tconst
    import sm3_cmp_pkg::*;
#(
    parameter int CNT_W         = 6,
    parameter int PARITY_ROUNDS = 16
) (
    input  logic [CNT_W-1:0] round_i,
    output word_t            t_o
);
    word_t             base;
    logic [ROT_W-1:0]  amt;

    always_comb begin
        base = (round_i < CNT_W'(PARITY_ROUNDS)) ? T_EARLY : T_LATE;
        amt  = ROT_W'(round_i);
        t_o  = rotl_v(base, amt);
    end
endmodule

// File: rtl/sm3_round.sv
`timescale 1ns/1ps
module sm3_round
    import sm3_cmp_pkg::*;
#(
    parameter int CNT_W         = 6,
    parameter int PARITY_ROUNDS = 16
) (
    input  wstate_t          st_i,
    input  word_t            w_i,
    input  word_t            wp_i,
    input  word_t            t_i,
    input  logic [CNT_W-1:0] round_i,
    output wstate_t          st_o
);
    logic  early;
    word_t a12, ss1, ss2, ff, gg, tt1, tt2;

    always_comb begin
        early = (round_i < CNT_W'(PARITY_ROUNDS));
        a12   = rotl_k(st_i.a, 12);
        ss1   = rotl_k(a12 + st_i.e + t_i, 7);
        ss2   = ss1 ^ a12;
        if (early) begin
            ff = st_i.a ^ st_i.b ^ st_i.c;
            gg = st_i.e ^ st_i.f ^ st_i.g;
        end else begin
            ff = ((st_i.a | st_i.c) & st_i.b) | (st_i.a & st_i.c);
            gg = ((st_i.f ^ st_i.g) & st_i.e) ^ st_i.g;
        end
        tt1 = ff + st_i.d + ss2 + wp_i;
        tt2 = gg + st_i.h + ss1 + w_i;

        st_o.a = tt1;
        st_o.b = st_i.a;
        st_o.c = rotl_k(st_i.b, 9);
        st_o.d = st_i.c;
        st_o.e = perm0(tt2);
        st_o.f = st_i.e;
        st_o.g = rotl_k(st_i.f, 19);
        st_o.h = st_i.g;
    end
endmodule

// File: rtl/sm3_cmp_core.sv
`timescale 1ns/1ps
module sm3_cmp_core
    import sm3_cmp_pkg::*;
#(
    parameter int NUM_ROUNDS    = 64,
    parameter int PARITY_ROUNDS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            use_iv_i,
    input  logic [CV_W-1:0] cv_i,
    input  logic            w_valid_i,
    input  logic [WORD_W-1:0] w_i,
    input  logic [WORD_W-1:0] wp_i,
    output logic            w_ready_o,
    output logic            busy_o,
    output logic            done_o,
    output logic [CV_W-1:0] cv_o
);
    localparam int               CNT_W = $clog2(NUM_ROUNDS);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(NUM_ROUNDS - 1);

    typedef struct packed {
        wstate_t          work;
        logic [CV_W-1:0]  chain;
        logic [CNT_W-1:0] rnd;
        logic             busy;
        logic             done;
    } core_t;

    core_t   r_q, r_d;
    wstate_t rnd_st;
    word_t   t_cur;
    logic    fire_d;

    sm3_tconst #(.CNT_W(CNT_W), .PARITY_ROUNDS(PARITY_ROUNDS)) u_tconst (
        .round_i (r_q.rnd),
        .t_o     (t_cur)
    );

    sm3_round #(.CNT_W(CNT_W), .PARITY_ROUNDS(PARITY_ROUNDS)) u_round (
        .st_i    (r_q.work),
        .w_i     (w_i),
        .wp_i    (wp_i),
        .t_i     (t_cur),
        .round_i (r_q.rnd),
        .st_o    (rnd_st)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        fire_d   = r_q.busy && w_valid_i;
        if (!r_q.busy && start_i) begin
            r_d.chain = use_iv_i ? SM3_IV : cv_i;
            r_d.work  = wstate_t'(use_iv_i ? SM3_IV : cv_i);
            r_d.rnd   = '0;
            r_d.busy  = 1'b1;
        end else if (fire_d) begin
            r_d.work = rnd_st;
            r_d.rnd  = r_q.rnd + 1'b1;
            if (r_q.rnd == LAST) begin
                r_d.chain = rnd_st ^ r_q.chain;
                r_d.busy  = 1'b0;
                r_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o    = r_q.busy;
    assign w_ready_o = r_q.busy;
    assign done_o    = r_q.done;
    assign cv_o      = r_q.chain;

    // R2: an idle start enters round 0 with busy set
    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && r_q.rnd == '0));

    // R4: no valid word pair, no progress
    a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !w_valid_i) |=> ($stable(r_q.rnd) && $stable(r_q.work) && busy_o));

    // R7: a start while busy does not end or restart the block
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && r_q.rnd != LAST) |=> (busy_o && !done_o));

    // R8: done lasts one cycle and coincides with idle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(cv_o));
endmodule

// File: tb/tb_sm3_cmp_core.sv
`timescale 1ns/1ps
module tb_sm3_cmp_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         use_iv_i = 1'b0;
    logic [255:0] cv_i = '0;
    logic         w_valid_i = 1'b0;
    logic [31:0]  w_i = '0;
    logic [31:0]  wp_i = '0;
    logic         w_ready_o, busy_o, done_o;
    logic [255:0] cv_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sm3_cmp_core dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .use_iv_i(use_iv_i),
        .cv_i(cv_i), .w_valid_i(w_valid_i), .w_i(w_i), .wp_i(wp_i),
        .w_ready_o(w_ready_o), .busy_o(busy_o), .done_o(done_o), .cv_o(cv_o)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int k);
        int s = k % 32;
        if (s == 0) return x;
        return (x << s) | (x >> (32 - s));
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [31:0] mv[8];
    logic [31:0] mch[8];
    int          mcnt;
    bit          mbusy, mdone;

    function automatic logic [255:0] pack8(input logic [31:0] v[8]);
        logic [255:0] r = '0;
        for (int i = 0; i < 8; i++) r[255 - 32*i -: 32] = v[i];
        return r;
    endfunction

    task automatic model_round(input int j, input logic [31:0] w, input logic [31:0] wp);
        logic [31:0] tj, s1, s2, f1, g1, x1, x2, p;
        logic [31:0] nv[8];
        tj = rl((j < 16) ? 32'h79cc4519 : 32'h7a879d8a, j);
        s1 = rl(rl(mv[0], 12) + mv[4] + tj, 7);
        s2 = s1 ^ rl(mv[0], 12);
        if (j < 16) begin
            f1 = mv[0] ^ mv[1] ^ mv[2];
            g1 = mv[4] ^ mv[5] ^ mv[6];
        end else begin
            f1 = (mv[0] & mv[1]) | (mv[0] & mv[2]) | (mv[1] & mv[2]);
            g1 = (mv[4] & mv[5]) | (~mv[4] & mv[6]);
        end
        x1 = f1 + mv[3] + s2 + wp;
        x2 = g1 + mv[7] + s1 + w;
        p  = x2 ^ rl(x2, 9) ^ rl(x2, 17);
        nv[0] = x1; nv[1] = mv[0]; nv[2] = rl(mv[1], 9); nv[3] = mv[2];
        nv[4] = p;  nv[5] = mv[4]; nv[6] = rl(mv[5], 19); nv[7] = mv[6];
        for (int i = 0; i < 8; i++) mv[i] = nv[i];
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mbusy = 0; mdone = 0; mcnt = 0;
            for (int i = 0; i < 8; i++) begin mv[i] = '0; mch[i] = '0; end
        end else begin
            mdone = 0;
            if (!mbusy && start_i) begin
                for (int i = 0; i < 8; i++) begin
                    mch[i] = use_iv_i ? rl(32'h0, 0) : cv_i[255 - 32*i -: 32];
                end
                if (use_iv_i) begin
                    mch[0] = 32'h7380166f; mch[1] = 32'h4914b2b9;
                    mch[2] = 32'h172442d7; mch[3] = 32'hda8a0600;
                    mch[4] = 32'ha96f30bc; mch[5] = 32'h163138aa;
                    mch[6] = 32'he38dee4d; mch[7] = 32'hb0fb0e4e;
                end
                for (int i = 0; i < 8; i++) mv[i] = mch[i];
                mcnt = 0; mbusy = 1;
            end else if (mbusy && w_valid_i) begin
                model_round(mcnt, w_i, wp_i);
                mcnt++;
                if (mcnt == 64) begin
                    for (int i = 0; i < 8; i++) mch[i] = mch[i] ^ mv[i];
                    mbusy = 0; mdone = 1;
                end
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 R4 busy", {255'd0, busy_o}, {255'd0, mbusy});
            chk("R3 ready", {255'd0, w_ready_o}, {255'd0, mbusy});
            chk("R8 done", {255'd0, done_o}, {255'd0, mdone});
            if (mdone) chk("R6 R9 model result", cv_o, pack8(mch));
        end
    end

    // ---------------- stimulus ----------------
    function automatic void expand(input logic [31:0] blk[16], output logic [31:0] w[68]);
        for (int i = 0; i < 16; i++) w[i] = blk[i];
        for (int i = 16; i < 68; i++) begin
            logic [31:0] t = w[i-16] ^ w[i-9] ^ rl(w[i-3], 15);
            w[i] = (t ^ rl(t, 15) ^ rl(t, 23)) ^ rl(w[i-13], 7) ^ w[i-6];
        end
    endfunction

    task automatic run_block(input logic [31:0] blk[16], input bit iv, input logic [255:0] cv,
                             input int gap_every, input bit poke_start,
                             output logic [255:0] res);
        logic [31:0] w[68];
        expand(blk, w);
        @(negedge clk); #1;
        start_i = 1; use_iv_i = iv; cv_i = cv;
        @(negedge clk); #1;
        start_i = 0;
        chk("R2 busy after start", {255'd0, busy_o}, {255'd0, 1'b1});
        for (int j = 0; j < 64; j++) begin
            if (gap_every != 0 && (j % gap_every) == 0) begin
                w_valid_i = 0;
                @(negedge clk); #1;
            end
            if (poke_start && j == 20) begin
                start_i = 1; use_iv_i = 0; cv_i = {8{32'hdeadbeef}};
            end else begin
                start_i = 0;
            end
            w_valid_i = 1; w_i = w[j]; wp_i = w[j] ^ w[j+4];
            @(negedge clk); #1;
        end
        start_i = 0; w_valid_i = 0;
        chk("R4 done after last pair", {255'd0, done_o}, {255'd0, 1'b1});
        res = cv_o;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0]  blk[16];
        logic [255:0] r1, r2, hold;
        #1;
        chk("R1 reset busy/ready/done", {253'd0, busy_o, w_ready_o, done_o}, 256'd0);
        #11 rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", {253'd0, busy_o, w_ready_o, done_o}, 256'd0);

        // R3: valid while idle is not accepted
        w_valid_i = 1; @(negedge clk);
        chk("R3 ready low while idle", {255'd0, w_ready_o}, 256'd0);
        #1 w_valid_i = 0;

        // R5 R6: one-block "abc"
        for (int i = 0; i < 16; i++) blk[i] = '0;
        blk[0] = 32'h61626380; blk[15] = 32'h00000018;
        run_block(blk, 1, '0, 0, 0, r1);
        chk("R5 R6 abc digest", r1,
            256'h66c7f0f4_62eeedd9_d1f2d46b_dc10e4e2_4167c487_5cf2f7a2_297da02b_8f4ba8e0);

        // R8: result held while word interface toggles
        hold = cv_o;
        for (int k = 0; k < 4; k++) begin
            w_valid_i = k[0]; w_i = 32'h12345678 * k;
            @(negedge clk); #1;
        end
        w_valid_i = 0;
        chk("R8 result held", cv_o, hold);
        chk("R8 idle after done", {254'd0, busy_o, done_o}, 256'd0);

        // R4 R7 R9: 64-byte message over two blocks, stalls and a mid-block start
        for (int i = 0; i < 16; i++) blk[i] = 32'h61626364;
        run_block(blk, 1, {8{32'h5a5a5a5a}}, 3, 1, r1);
        for (int i = 0; i < 16; i++) blk[i] = '0;
        blk[0] = 32'h80000000; blk[15] = 32'h00000200;
        run_block(blk, 0, r1, 7, 0, r2);
        chk("R7 R9 two-block digest", r2,
            256'hdebe9ff9_2275b8a1_38604889_c18e5a4d_6fdb70e5_387e5765_293dcba3_9c0c5732);

        // R2: arbitrary chaining input, compared against the model
        for (int i = 0; i < 16; i++) blk[i] = 32'h01010101 * i + 32'h9e3779b9;
        run_block(blk, 0, 256'h0123456789abcdef_fedcba9876543210_0f1e2d3c4b5a6978_8796a5b4c3d2e1f0,
                  5, 0, r1);
        chk("R2 R6 cv_i path result", r1, pack8(mch));

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule